// File: doc/BRIEF.md
# Eight-Channel Four-of-Five Vote Filter

This block removes interference from eight digitised sensor status lines. Every channel takes its comparator bit through a two-flop synchroniser. It records the bit in a five-deep history only on clock cycles where the slow filter strobe is high. The strobe stands in for the filter oscillator and is a one-cycle pulse in the system clock domain.

After each new sample, the channel counts the ones in its history, including the newest sample. If at least four of the five samples are 1, the filtered bit is driven to 1. If at least four are 0, it is driven to 0. Any three-to-two split leaves the filtered bit where it was. A lone disturbed sample therefore never reaches the output. A real change in level shows up only after it has persisted for four strobe periods.

Top module: `mvf_filter_bank`

## Requirements
- R1: Each of the eight channels filters its own input bit `raw_i[c]` into `flt_o[c]` with its own history and held output; activity on one channel never changes another channel's output.
- R2: The history shifts only on a rising clock edge where `tick_i` is 1. With `tick_i` at 0, neither the history nor `flt_o` changes, whatever `raw_i` does.
- R3: After a shift, a history holding four or five 1s sets the channel's output to 1, and a history holding four or five 0s clears it to 0.
- R4: After a shift, a history holding three 1s and two 0s, or two 1s and three 0s, leaves the output at its previous value.
- R5: The vote uses the history as it stands after the shift, including the newest sample. `flt_o` takes its new value at the same clock edge that stores that sample.
- R6: An active-low `rst_n` asynchronously clears every history bit, both synchroniser stages and every output bit to 0.
- R7: `raw_i` passes through two clocked stages before it is sampled. A strobe edge stores the value that `raw_i` had two edges earlier.
- R8: With an all-0 history and the input held at 1, the output stays 0 after three strobes and becomes 1 on the fourth. A single opposing sample inside a full history never changes the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Filter sample strobe, synchronous to `clk` |
| raw_i | input | 8 | Raw comparator bits, asynchronous to `clk` |
| flt_o | output | 8 | Filtered status bits, one per channel |

## Verification
The in-RTL properties assume that `tick_i` is already in the `clk` domain and changes only between edges. They also assume that the synchronised sample seen by a channel is valid at each edge. `raw_i` itself may change at any time, because the properties look only at the synchronised bit. The stimulus drives both `tick_i` and `raw_i` on the falling clock edge. Before every directed sample, `raw_i` is held for at least three cycles, so the strobe stores a settled value. The random phase flips only a few input bits at a time and raises the strobe on roughly a third of the cycles.

// File: rtl/mvf_pkg.sv
package mvf_pkg;

    typedef enum logic [1:0] {
        VOTE_HOLD  = 2'd0,
        VOTE_SET   = 2'd1,
        VOTE_CLEAR = 2'd2
    } vote_e;

    // population count of the low `width` bits of a history word
    function automatic int unsigned ones_in(logic [31:0] vec, int unsigned width);
        int unsigned n;
        n = 0;
        for (int unsigned i = 0; i < 32; i++) begin
            if (i < width && vec[i]) n++;
        end
        return n;
    endfunction

    // decision for one window: set wins if both thresholds would be met
    function automatic vote_e decide(int unsigned ones, int unsigned width, int unsigned agree);
        if (ones >= agree)              return VOTE_SET;
        else if (width - ones >= agree) return VOTE_CLEAR;
        else                            return VOTE_HOLD;
    endfunction

endpackage

// File: rtl/mvf_sync.sv
module mvf_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/mvf_lane.sv
module mvf_lane
    import mvf_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int AGREE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic sample_i,
    output logic flt_o
);

    typedef struct packed {
        logic [DEPTH-1:0] hist;
        logic             flt;
    } lane_t;

    lane_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.hist = {st_q.hist[DEPTH-2:0], sample_i};
            unique case (decide(ones_in(32'(st_d.hist), DEPTH), DEPTH, AGREE))
                VOTE_SET:   st_d.flt = 1'b1;
                VOTE_CLEAR: st_d.flt = 1'b0;
                default:    st_d.flt = st_q.flt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flt_o = st_q.flt;

    // R2: idle strobe freezes history and output
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> ($stable(flt_o) && $stable(st_q.hist)));

    // R3: enough 1s after the shift drives the output high
    a_r3_agree_high: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && sample_i && ($countones(st_q.hist[DEPTH-2:0]) >= AGREE - 1)) |=> flt_o);

    // R3: enough 0s after the shift drives the output low
    a_r3_agree_low: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !sample_i && ($countones(~st_q.hist[DEPTH-2:0]) >= AGREE - 1)) |=> !flt_o);

    // R4: a window meeting neither threshold keeps the output
    a_r4_split_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i
         && ($countones({st_q.hist[DEPTH-2:0], sample_i}) < AGREE)
         && ($countones(~{st_q.hist[DEPTH-2:0], sample_i}) < AGREE))
        |=> $stable(flt_o));

endmodule

// File: rtl/mvf_filter_bank.sv
module mvf_filter_bank #(
    parameter int CHANNELS    = 8,
    parameter int DEPTH       = 5,
    parameter int AGREE       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic [CHANNELS-1:0] raw_i,
    output logic [CHANNELS-1:0] flt_o
);

    logic [CHANNELS-1:0] sampled;

    mvf_sync #(
        .WIDTH  (CHANNELS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_i),
        .sync_o  (sampled)
    );

    for (genvar c = 0; c < CHANNELS; c++) begin : g_lane
        mvf_lane #(
            .DEPTH (DEPTH),
            .AGREE (AGREE)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick_i),
            .sample_i (sampled[c]),
            .flt_o    (flt_o[c])
        );
    end

    // R1: a lane whose synchronised input matches its output never moves
    a_r1_quiet_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(flt_o) ^ flt_o) & ~($past(sampled) ^ $past(flt_o))) == '0));

endmodule

// File: tb/mvf_filter_bank_test.sv
`timescale 1ns/1ps
module mvf_filter_bank_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] raw = 8'h00;
    wire  [7:0] flt;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    mvf_filter_bank uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .raw_i  (raw),
        .flt_o  (flt)
    );

    // behavioural reference
    logic [7:0] rawq [$];
    bit         win [8][$];
    logic [7:0] mout = 8'h00;

    task automatic model_edge();
        logic [7:0] synced;
        int ones;
        if (!rst_n) begin
            rawq.delete();
            for (int c = 0; c < 8; c++) begin
                win[c].delete();
                for (int k = 0; k < 5; k++) win[c].push_back(1'b0);
            end
            mout = 8'h00;
        end else begin
            rawq.push_back(raw);
            synced = (rawq.size() >= 3) ? rawq[rawq.size()-3] : 8'h00;
            if (rawq.size() > 3) void'(rawq.pop_front());
            if (tick) begin
                for (int c = 0; c < 8; c++) begin
                    win[c].push_back(synced[c]);
                    void'(win[c].pop_front());
                    ones = 0;
                    foreach (win[c][k]) ones += int'(win[c][k]);
                    if (ones >= 4)      mout[c] = 1'b1;
                    else if (ones <= 1) mout[c] = 1'b0;
                end
            end
        end
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        model_edge();
        check("R1/R3/R5 per-cycle model", flt, mout);
    endtask

    task automatic settle(int n);
        repeat (n) cyc();
    endtask

    task automatic pulse(int n);
        repeat (n) begin
            tick = 1'b1;
            cyc();
            tick = 1'b0;
        end
    endtask

    initial begin
        settle(3);
        check("R6 reset clears outputs", flt, 8'h00);
        rst_n = 1'b1;

        // R7: strobes right after the change still see the old level
        raw = 8'hFF;
        tick = 1'b1;
        settle(5);
        check("R7 two-stage delay, not yet set", flt, 8'h00);
        settle(1);
        check("R7 set on fourth stored 1", flt, 8'hFF);
        tick = 1'b0;

        // R8: single opposing sample in a full history
        raw = 8'h00; settle(3); pulse(1);
        check("R8 single glitch ignored", flt, 8'hFF);
        raw = 8'hFF; settle(3); pulse(2);
        check("R8 glitch aged out", flt, 8'hFF);
        pulse(3);

        // R4: three zeros hold, fourth clears
        raw = 8'h00; settle(3); pulse(3);
        check("R4 split window holds", flt, 8'hFF);
        pulse(1);
        check("R3 four zeros clear", flt, 8'h00);

        // R2: no strobe, no sampling
        raw = 8'hFF; settle(20);
        check("R2 idle strobe no change", flt, 8'h00);
        pulse(3);
        check("R2 history kept across idle", flt, 8'h00);
        pulse(1);
        check("R2 set after fourth strobe", flt, 8'hFF);

        // R8: steady level from opposite full history
        raw = 8'h00; settle(3); pulse(5);
        check("R3 full zero history", flt, 8'h00);
        raw = 8'hFF; settle(3); pulse(3);
        check("R8 three samples insufficient", flt, 8'h00);
        pulse(1);
        check("R8 fourth sample flips", flt, 8'hFF);
        pulse(1);

        // R1: half the lanes change, the rest keep their state
        raw = 8'h0F; settle(3); pulse(4);
        check("R1 independent lanes", flt, 8'h0F);

        // random phase compared against the model every cycle
        for (int i = 0; i < 3000; i++) begin
            raw  = raw ^ 8'($urandom() & $urandom() & $urandom());
            tick = ($urandom() % 3) == 0;
            cyc();
        end
        tick = 1'b0;

        // R6: mid-run reset wipes history
        rst_n = 1'b0;
        cyc();
        check("R6 mid-run reset clears", flt, 8'h00);
        rst_n = 1'b1;
        raw = 8'hFF; settle(3); pulse(3);
        check("R6 history cleared by reset", flt, 8'h00);
        pulse(1);
        check("R6 fresh set after reset", flt, 8'hFF);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog all-requirements actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule